// File: doc/BRIEF.md
# Wraparound Concatenating Register File

This block stores twenty-four 16-bit words. Sixteen of them form the user set, addressed by a 4-bit index. The other eight form a separate microcode set, reached only while a space-select input is high. Two independent read ports, called R and S, return operands combinationally from their address inputs. One write port commits on the rising clock edge.

A caller asks for an operand of one, two or three words by naming the register that holds its most significant word. The following words come from the next registers up, and the index wraps inside the user set, so index 15 is followed by index 0. Operands are right-aligned on the 48-bit data buses. Word k of an n-word operand (k = 0 is the named register) sits at bits [(n-1-k)*16 +: 16]. Bus bits above the operand are zero on reads and ignored on writes.

The write port stores all the words of an operand in a single clock cycle. A read that addresses a register being written in the same cycle sees the value held before the edge.

Top module: `wrap_regfile`

## Requirements
- R1: While reset is asserted (active low) every one of the 24 registers is cleared, so every read returns zero afterwards until a write occurs.
- R2: A size code of 2'b00 (or the reserved 2'b11) reads one word: the named user register appears in bits [15:0] and bits [47:16] are zero.
- R3: Size code 2'b01 reads two words: the named register appears in bits [31:16], the next register up in bits [15:0], and bits [47:32] are zero.
- R4: Size code 2'b10 reads three words: the named register appears in bits [47:32], the next register in [31:16] and the one after that in [15:0].
- R5: Successor indices wrap modulo 16 inside the user set. A two-word operand at index 15 uses 15 then 0, and a three-word operand at 15 uses 15, 0, 1.
- R6: With the space select high, a read returns microcode register (index mod 8) in bits [15:0], whatever the size code, with bits [47:16] zero.
- R7: A user write with wr_en high stores 1, 2 or 3 words at the clock edge, using the same size codes, word placement and wraparound as a read. No other register changes.
- R8: A microcode-space write stores only wr_data[15:0] into microcode register (index mod 8), whatever the size code, and leaves every user register unchanged.
- R9: The R and S ports decode independently, so both return their own operands in the same cycle.
- R10: A read and a write to the same register in one cycle return the old value on the read; the new value is visible after the edge.
- R11: With wr_en low no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| wr_en | input | 1 | Write enable |
| wr_ucode | input | 1 | Write targets the microcode set |
| wr_idx | input | 4 | Index of the most significant word to write |
| wr_size | input | 2 | Write size code (00/11 one word, 01 two, 10 three) |
| wr_data | input | 48 | Right-aligned write operand |
| pr_ucode | input | 1 | Port R addresses the microcode set |
| pr_idx | input | 4 | Port R index of the most significant word |
| pr_size | input | 2 | Port R size code |
| pr_data | output | 48 | Port R right-aligned operand |
| ps_ucode | input | 1 | Port S addresses the microcode set |
| ps_idx | input | 4 | Port S index of the most significant word |
| ps_size | input | 2 | Port S size code |
| ps_data | output | 48 | Port S right-aligned operand |

## Verification
A read and a write often fall in the same cycle, and they can overlap, including across the wrap boundary. A write of three words at index 14 can land on R15 and R0 while a port reads one of those registers. Each stimulus vector drives its write together with both reads. The bench samples the reads just before the edge and expects the stored value from before the write. A later vector reads the same registers to confirm that the new words, including the wrapped ones, landed.

// File: rtl/wrap_regfile_pkg.sv
package wrap_regfile_pkg;
    localparam int DW     = 16;
    localparam int MAXW   = 3;
    localparam int NUSER  = 16;
    localparam int NMC    = 8;
    localparam int NREG   = NUSER + NMC;
    localparam int UAW    = $clog2(NUSER);
    localparam int MAW    = $clog2(NMC);
    localparam int PW     = $clog2(NREG);
    localparam int OW     = DW * MAXW;

    typedef enum logic [1:0] {
        SZ_ONE   = 2'b00,
        SZ_TWO   = 2'b01,
        SZ_THREE = 2'b10,
        SZ_RSVD  = 2'b11
    } op_size_e;
endpackage

// File: rtl/wrap_regfile_addr.sv
module wrap_regfile_addr
    import wrap_regfile_pkg::*;
(
    input  logic                      ucode,
    input  logic [UAW-1:0]            idx,
    input  logic [1:0]                size,
    output logic [MAXW-1:0][PW-1:0]   phys,
    output logic [1:0]                nwords
);
    always_comb begin
        if (ucode) begin
            nwords = 2'd1;
        end else begin
            unique case (op_size_e'(size))
                SZ_TWO:   nwords = 2'd2;
                SZ_THREE: nwords = 2'd3;
                default:  nwords = 2'd1;
            endcase
        end
    end

    for (genvar k = 0; k < MAXW; k++) begin : g_word
        logic [UAW-1:0] succ;
        assign succ = idx + UAW'(k);
        assign phys[k] = ucode ? (PW'(NUSER) + PW'(idx[MAW-1:0]))
                               : PW'(succ);
    end
endmodule

// File: rtl/wrap_regfile_rdport.sv
module wrap_regfile_rdport
    import wrap_regfile_pkg::*;
(
    input  logic [NREG-1:0][DW-1:0]   regs,
    input  logic [MAXW-1:0][PW-1:0]   phys,
    input  logic [1:0]                nwords,
    output logic [OW-1:0]             data
);
    always_comb begin
        data = '0;
        for (int k = 0; k < MAXW; k++) begin
            if (k < int'(nwords)) begin
                data[(int'(nwords) - 1 - k) * DW +: DW] = regs[phys[k]];
            end
        end
    end
endmodule

// File: rtl/wrap_regfile.sv
module wrap_regfile
    import wrap_regfile_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_ucode,
    input  logic [UAW-1:0]  wr_idx,
    input  logic [1:0]      wr_size,
    input  logic [OW-1:0]   wr_data,
    input  logic            pr_ucode,
    input  logic [UAW-1:0]  pr_idx,
    input  logic [1:0]      pr_size,
    output logic [OW-1:0]   pr_data,
    input  logic            ps_ucode,
    input  logic [UAW-1:0]  ps_idx,
    input  logic [1:0]      ps_size,
    output logic [OW-1:0]   ps_data
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } rf_state_t;

    rf_state_t state_d, state_q;

    logic [MAXW-1:0][PW-1:0] wr_phys, pr_phys, ps_phys;
    logic [1:0]              wr_n, pr_n, ps_n;

    wrap_regfile_addr u_wr_addr (
        .ucode (wr_ucode), .idx (wr_idx), .size (wr_size),
        .phys  (wr_phys),  .nwords (wr_n)
    );
    wrap_regfile_addr u_pr_addr (
        .ucode (pr_ucode), .idx (pr_idx), .size (pr_size),
        .phys  (pr_phys),  .nwords (pr_n)
    );
    wrap_regfile_addr u_ps_addr (
        .ucode (ps_ucode), .idx (ps_idx), .size (ps_size),
        .phys  (ps_phys),  .nwords (ps_n)
    );

    wrap_regfile_rdport u_pr_port (
        .regs (state_q.regs), .phys (pr_phys), .nwords (pr_n), .data (pr_data)
    );
    wrap_regfile_rdport u_ps_port (
        .regs (state_q.regs), .phys (ps_phys), .nwords (ps_n), .data (ps_data)
    );

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            for (int k = 0; k < MAXW; k++) begin
                if (k < int'(wr_n)) begin
                    state_d.regs[wr_phys[k]] = wr_data[(int'(wr_n) - 1 - k) * DW +: DW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/wrap_regfile_chk.sv
module wrap_regfile_chk
    import wrap_regfile_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_ucode,
    input  logic [UAW-1:0]           wr_idx,
    input  logic [1:0]               wr_size,
    input  logic [OW-1:0]            wr_data,
    input  logic                     pr_ucode,
    input  logic [UAW-1:0]           pr_idx,
    input  logic [1:0]               pr_size,
    input  logic [OW-1:0]            pr_data,
    input  logic [NREG-1:0][DW-1:0]  regs
);
    AST_ONE_WORD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ucode && wr_size == 2'b00)
        |=> regs[$past(wr_idx)] == $past(wr_data[DW-1:0])); // R7

    AST_UCODE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pr_ucode |-> pr_data[OW-1:DW] == '0); // R6

    AST_PAIR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pr_ucode && pr_size == 2'b01)
        |-> (pr_data[2*DW-1:DW] == regs[pr_idx]
             && pr_data[DW-1:0] == regs[UAW'(pr_idx + 1'b1)])); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs)); // R11

    AST_UCODE_WR_SPARES_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ucode)
        |=> regs[NUSER-1:0] == $past(regs[NUSER-1:0])); // R8
endmodule

bind wrap_regfile wrap_regfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ucode (wr_ucode),
    .wr_idx   (wr_idx),
    .wr_size  (wr_size),
    .wr_data  (wr_data),
    .pr_ucode (pr_ucode),
    .pr_idx   (pr_idx),
    .pr_size  (pr_size),
    .pr_data  (pr_data),
    .regs     (state_q.regs)
);

// File: tb/wrap_regfile_tb.sv
module wrap_regfile_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wen;
        logic        wuc;
        logic [3:0]  widx;
        logic [1:0]  wsz;
        logic [47:0] wdata;
        logic        ruc;
        logic [3:0]  ridx;
        logic [1:0]  rsz;
        logic [47:0] rexp;
        logic        suc;
        logic [3:0]  sidx;
        logic [1:0]  ssz;
        logic [47:0] sexp;
    } vec_t;

    // Reads are sampled before the edge of the same vector's write.
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // R4 R5 write three words at 14; S reads R14 in same cycle -> old (R10)
        '{1'b1,1'b0,4'd14,2'b10,48'hAAAA_BBBB_CCCC, 1'b0,4'd0,2'b00,48'h0, 1'b0,4'd14,2'b00,48'h0},
        // R4 R5 read three at 14; R3 R5 read two at 15; write two at 15 (R7)
        '{1'b1,1'b0,4'd15,2'b01,48'h0000_1111_2222, 1'b0,4'd14,2'b10,48'hAAAA_BBBB_CCCC, 1'b0,4'd15,2'b01,48'h0000_BBBB_CCCC},
        // R8 microcode write with size 10 stores low word only
        '{1'b1,1'b1,4'd3,2'b10,48'hDEAD_BEEF_5555, 1'b0,4'd15,2'b01,48'h0000_1111_2222, 1'b0,4'd14,2'b00,48'h0000_0000_AAAA},
        // R6 microcode read ignores size; user R3 untouched by microcode write
        '{1'b1,1'b0,4'd1,2'b00,48'h0000_0000_3333, 1'b1,4'd3,2'b10,48'h0000_0000_5555, 1'b0,4'd3,2'b00,48'h0},
        // R11 disabled write; R5 three at 15 -> R15,R0,R1; R6 index 11 maps to M3
        '{1'b0,1'b0,4'd2,2'b00,48'hFFFF_FFFF_FFFF, 1'b0,4'd15,2'b10,48'h1111_2222_3333, 1'b1,4'd11,2'b00,48'h0000_0000_5555},
        // R11 R2 after disabled write R2 still zero; reserved size reads one word
        '{1'b1,1'b0,4'd2,2'b11,48'hFFFF_FFFF_7777, 1'b0,4'd2,2'b00,48'h0, 1'b0,4'd14,2'b11,48'h0000_0000_AAAA},
        // R2 R3 R9 two ports at once
        '{1'b1,1'b0,4'd5,2'b01,48'h0000_4444_6666, 1'b0,4'd2,2'b00,48'h0000_0000_7777, 1'b0,4'd1,2'b01,48'h0000_3333_7777},
        // R4 R3
        '{1'b0,1'b0,4'd0,2'b00,48'h0, 1'b0,4'd4,2'b10,48'h0000_4444_6666, 1'b0,4'd6,2'b01,48'h0000_6666_0000},
        // R10 microcode write M0, same-cycle read old
        '{1'b1,1'b1,4'd0,2'b00,48'h0000_0000_9999, 1'b1,4'd0,2'b00,48'h0, 1'b0,4'd0,2'b00,48'h0000_0000_2222},
        // R8 user R0 unaffected by microcode write; M0 now visible
        '{1'b0,1'b0,4'd0,2'b00,48'h0, 1'b1,4'd0,2'b00,48'h0000_0000_9999, 1'b0,4'd0,2'b00,48'h0000_0000_2222}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_ucode = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [1:0]  wr_size = '0;
    logic [47:0] wr_data = '0;
    logic        pr_ucode = 1'b0, ps_ucode = 1'b0;
    logic [3:0]  pr_idx = '0, ps_idx = '0;
    logic [1:0]  pr_size = '0, ps_size = '0;
    logic [47:0] pr_data, ps_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrap_regfile u_dut (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_ucode (wr_ucode), .wr_idx (wr_idx),
        .wr_size (wr_size), .wr_data (wr_data),
        .pr_ucode (pr_ucode), .pr_idx (pr_idx), .pr_size (pr_size), .pr_data (pr_data),
        .ps_ucode (ps_ucode), .ps_idx (ps_idx), .ps_size (ps_size), .ps_data (ps_data)
    );

    task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_reads(input logic ru, input logic [3:0] ri, input logic [1:0] rs,
                             input logic su, input logic [3:0] si, input logic [1:0] ss);
        pr_ucode = ru; pr_idx = ri; pr_size = rs;
        ps_ucode = su; ps_idx = si; ps_size = ss;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        set_reads(1'b0, 4'd15, 2'b10, 1'b1, 4'd7, 2'b00);
        #1;
        check("R1 user after reset", pr_data, 48'h0);
        check("R1 microcode after reset", ps_data, 48'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].wen; wr_ucode = VECS[i].wuc; wr_idx = VECS[i].widx;
            wr_size = VECS[i].wsz; wr_data = VECS[i].wdata;
            set_reads(VECS[i].ruc, VECS[i].ridx, VECS[i].rsz,
                      VECS[i].suc, VECS[i].sidx, VECS[i].ssz);
            #1;
            check($sformatf("R2 R3 R4 R5 R6 R10 vector %0d port R", i), pr_data, VECS[i].rexp);
            check($sformatf("R2 R3 R4 R5 R6 R8 R9 vector %0d port S", i), ps_data, VECS[i].sexp);
        end

        // R7 R5 three-word write at 15 wraps to R0 and R1; R10 old value first
        @(negedge clk);
        wr_en = 1'b1; wr_ucode = 1'b0; wr_idx = 4'd15; wr_size = 2'b10;
        wr_data = 48'h0123_4567_89AB;
        set_reads(1'b0, 4'd0, 2'b01, 1'b0, 4'd15, 2'b00);
        #1;
        check("R10 old pair at R0", pr_data, 48'h0000_2222_3333);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R7 R5 wrapped pair at R0", pr_data, 48'h0000_4567_89AB);
        check("R7 top word at R15", ps_data, 48'h0000_0000_0123);

        // R1 reset mid-run clears both sets
        @(negedge clk);
        rst_n = 1'b0;
        set_reads(1'b0, 4'd15, 2'b10, 1'b1, 4'd0, 2'b00);
        #1;
        check("R1 user cleared by reset", pr_data, 48'h0);
        check("R1 microcode cleared by reset", ps_data, 48'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule